// File: doc/BRIEF.md
# Streaming Burst Master Sequencer

This block is the bus-master side of a block transfer. A command gives a start address, a byte count, a direction, a beat width (two or four bytes) and whether the target is I/O space. The sequencer opens an ordinary single-address cycle: it raises status with the address, pulses the address latch, then raises command. At the end of the latch cycle it samples the slave's streaming-capability response. If the response is low, the cycle ends as one basic transfer. If it is high, the cycle continues as a strobed burst. In the burst, each strobe falling edge either counts a beat or repeats it, depending on the slave's returned ready.

The strobe is modelled as a level (`strb_o`) stepped by the system clock. A stall input lets the master stretch either strobe phase. The burst ends for one of three reasons: the byte count is used up, the slave withdraws its capability response, or a preempt request has been held for a configured number of clocks. A running byte count and a restart address are kept so that an interrupted block can be resumed.

Top module: `stream_burst_master`

## Requirements
- R1: After `start` is accepted in idle, the next cycle shows status active (`stat_wr_o` for a write, `stat_rd_o` for a read) with `bus_addr` equal to the start address. The cycle after that shows the address latch active with command inactive. The cycle after that shows command active with the address latch inactive.
- R2: If `sdr_in` is low at the clock edge that ends the latch cycle, status drops as command rises and the strobe stays idle. Command is held until `rdy_rtn` is seen high at an edge. The following cycle has command low, one beat counted and `done_o` high.
- R3: If `sdr_in` is high at that edge, the burst starts. When `rdy_rtn` is also high and `stall` is low, `strb_o` goes to 1 in the same cycle as command, and that first beat is counted. Otherwise `strb_o` stays 0 until an edge sees `rdy_rtn` high.
- R4: `strb_o`=1 means the strobe is at its active low level, so a 0-to-1 change of `strb_o` is a strobe falling edge. At each falling edge after the first, a high `rdy_rtn` gives a counted beat (`beat_take` for one cycle, same cycle as the edge). A low `rdy_rtn` gives a repeat (`beat_retry`) with the byte count unchanged. The strobe keeps alternating phases while the slave is not ready.
- R5: A counted beat moves 4 bytes when `start_wide`=1 and 2 bytes when `start_wide`=0. It moves fewer if fewer remain. The beat that exhausts the count drops status on its falling edge. Command and strobe drop one cycle later, with `done_o` high.
- R6: If `sdr_in` is seen low at an edge after the first counted beat, the burst ends at the point where the next falling edge would have been. Status, command and strobe all become inactive there, with no beat counted.
- R7: Once `preempt` is sampled high after the first counted beat, command goes inactive no later than PRE_LIM+4 clocks later. The stall input is overridden to reach the last falling edge.
- R8: While `stall` is high (and the preempt limit has not expired), `strb_o` holds its level and no beat or repeat occurs, in either strobe phase.
- R9: `bytes_done` holds the bytes counted since the last start. `resume_addr` equals the start address plus `bytes_done` when `start_io`=0, and the unchanged start address when `start_io`=1.
- R10: After reset, all bus controls, `busy`, `done_o`, the beat handshakes and `bytes_done` are 0. `done_o` pulses for one cycle exactly when command has just gone inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (taken only in idle) |
| start_addr | input | AW | Block start address |
| start_len | input | LW | Byte count, at least 1 |
| start_wr | input | 1 | 1 = write, 0 = read |
| start_wide | input | 1 | 1 = four-byte beats, 0 = two-byte beats |
| start_io | input | 1 | 1 = I/O space, 0 = memory space |
| stall | input | 1 | Master-side strobe stretch |
| rdy_rtn | input | 1 | Returned slave ready |
| sdr_in | input | 1 | Slave streaming-capability response |
| preempt | input | 1 | Request to release the bus |
| busy | output | 1 | A cycle is in progress |
| bus_addr | output | AW | Address presented for the cycle |
| stat_wr_o | output | 1 | Write status active |
| stat_rd_o | output | 1 | Read status active |
| adl_o | output | 1 | Address latch active |
| cmd_o | output | 1 | Command active |
| strb_o | output | 1 | Streaming strobe at active level |
| beat_take | output | 1 | Beat counted; advance data |
| beat_retry | output | 1 | Beat refused; repeat data |
| done_o | output | 1 | Cycle finished |
| bytes_done | output | LW | Bytes moved in this block |
| resume_addr | output | AW | Restart address after early end |

## Verification
Every output is a register, so each result appears in the cycle after the clock edge that decides it. Status and the address appear one clock after `start`, the latch one clock later, and command one clock after that. Each beat decision shows on `strb_o`, `beat_take` or `beat_retry` in the cycle after its edge. The bench drives inputs and reads outputs on the falling clock edge, so each check falls midway between the deciding edge and the next one. A scoreboard queue holds the running byte total expected after each counted beat. Any beat that arrives early, late or uncalled-for shows up as a mismatch against the head of that queue.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ADDR  = 3'd1,
      ST_ADL   = 3'd2,
      ST_BASIC = 3'd3,
      ST_STRM  = 3'd4,
      ST_TAIL  = 3'd5
   } sbm_state_e;
endpackage

// File: rtl/sbm_count.sv
module sbm_count #(
   parameter int unsigned AW      = 24,
   parameter int unsigned LW      = 16,
   parameter bit          WIDE_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] ld_addr,
   input  logic [LW-1:0] ld_len,
   input  logic          ld_wide,
   input  logic          ld_io,
   input  logic          take,
   output logic          rem_last,
   output logic [LW-1:0] bytes_done,
   output logic [AW-1:0] resume_addr
);
   localparam logic [LW-1:0] NARROW_B = LW'(2);
   localparam logic [LW-1:0] WIDE_B   = LW'(4);

   logic [LW-1:0] rem_q, moved_q, bpb_q, step;
   logic [AW-1:0] base_q;
   logic          io_q;

   assign step     = (rem_q < bpb_q) ? rem_q : bpb_q;
   assign rem_last = (rem_q <= bpb_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q   <= '0;
         moved_q <= '0;
         bpb_q   <= NARROW_B;
         base_q  <= '0;
         io_q    <= 1'b0;
      end else if (load) begin
         rem_q   <= ld_len;
         moved_q <= '0;
         bpb_q   <= (WIDE_EN && ld_wide) ? WIDE_B : NARROW_B;
         base_q  <= ld_addr;
         io_q    <= ld_io;
      end else if (take) begin
         rem_q   <= rem_q - step;
         moved_q <= moved_q + step;
      end
   end

   assign bytes_done  = moved_q;
   assign resume_addr = io_q ? base_q : base_q + AW'(moved_q);
endmodule

// File: rtl/sbm_preempt.sv
module sbm_preempt #(
   parameter int unsigned PRE_LIM = 780
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   input  logic preempt,
   output logic expired
);
   localparam int unsigned CW = $clog2(PRE_LIM + 2);

   logic          armed_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else if (clr) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else begin
         if (run && preempt) armed_q <= 1'b1;
         if (armed_q && cnt_q != CW'(PRE_LIM)) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expired = armed_q && (cnt_q == CW'(PRE_LIM));
endmodule

// File: rtl/stream_burst_master.sv
module stream_burst_master
   import sbm_pkg::*;
#(
   parameter int unsigned AW      = 24,
   parameter int unsigned LW      = 16,
   parameter bit          WIDE_EN = 1'b1,
   parameter int unsigned PRE_LIM = 780
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] start_addr,
   input  logic [LW-1:0] start_len,
   input  logic          start_wr,
   input  logic          start_wide,
   input  logic          start_io,
   input  logic          stall,
   input  logic          rdy_rtn,
   input  logic          sdr_in,
   input  logic          preempt,
   output logic          busy,
   output logic [AW-1:0] bus_addr,
   output logic          stat_wr_o,
   output logic          stat_rd_o,
   output logic          adl_o,
   output logic          cmd_o,
   output logic          strb_o,
   output logic          beat_take,
   output logic          beat_retry,
   output logic          done_o,
   output logic [LW-1:0] bytes_done,
   output logic [AW-1:0] resume_addr
);
   if (AW < 4) begin : g_bad_aw
      $error("stream_burst_master: AW must be at least 4");
   end
   if (LW < 3 || LW > AW) begin : g_bad_lw
      $error("stream_burst_master: LW must lie in 3..AW");
   end

   logic wide_eff;
   if (WIDE_EN) begin : g_wide
      assign wide_eff = start_wide;
   end else begin : g_narrow
      assign wide_eff = 1'b0;
   end

   sbm_state_e    state_q;
   logic [AW-1:0] addr_q;
   logic          wr_q, stat_q, adl_q, cmd_q, strb_q;
   logic          take_q, retry_q, done_q, started_q, slv_end_q;

   logic in_strm, hold_ph, first_fall, fall_ev, rise_ev, end_ev;
   logic counted, retry, last_edge, basic_take, take, rem_last, pre_exp;

   assign in_strm    = (state_q == ST_STRM);
   assign hold_ph    = stall & ~pre_exp;
   assign first_fall = (state_q == ST_ADL) & sdr_in & rdy_rtn & ~stall;
   assign fall_ev    = first_fall |
                       (in_strm & ~strb_q & ~hold_ph & ~slv_end_q & (started_q | rdy_rtn));
   assign rise_ev    = in_strm & strb_q & ~hold_ph;
   assign end_ev     = in_strm & ~strb_q & ~hold_ph & slv_end_q;
   assign counted    = fall_ev & rdy_rtn;
   assign retry      = fall_ev & ~rdy_rtn;
   assign last_edge  = fall_ev & (pre_exp | (counted & rem_last));
   assign basic_take = (state_q == ST_BASIC) & rdy_rtn;
   assign take       = counted | basic_take;

   sbm_count #(.AW(AW), .LW(LW), .WIDE_EN(WIDE_EN)) u_count (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       ((state_q == ST_IDLE) & start),
      .ld_addr    (start_addr),
      .ld_len     (start_len),
      .ld_wide    (wide_eff),
      .ld_io      (start_io),
      .take       (take),
      .rem_last   (rem_last),
      .bytes_done (bytes_done),
      .resume_addr(resume_addr)
   );

   sbm_preempt #(.PRE_LIM(PRE_LIM)) u_preempt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (state_q == ST_IDLE),
      .run    (in_strm & started_q),
      .preempt(preempt),
      .expired(pre_exp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         addr_q    <= '0;
         wr_q      <= 1'b0;
         stat_q    <= 1'b0;
         adl_q     <= 1'b0;
         cmd_q     <= 1'b0;
         strb_q    <= 1'b0;
         take_q    <= 1'b0;
         retry_q   <= 1'b0;
         done_q    <= 1'b0;
         started_q <= 1'b0;
         slv_end_q <= 1'b0;
      end else begin
         take_q  <= take;
         retry_q <= retry;
         done_q  <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               started_q <= 1'b0;
               slv_end_q <= 1'b0;
               if (start) begin
                  state_q <= ST_ADDR;
                  stat_q  <= 1'b1;
                  addr_q  <= start_addr;
                  wr_q    <= start_wr;
               end
            end
            ST_ADDR: begin
               state_q <= ST_ADL;
               adl_q   <= 1'b1;
            end
            ST_ADL: begin
               adl_q <= 1'b0;
               cmd_q <= 1'b1;
               if (sdr_in) begin
                  strb_q    <= first_fall;
                  started_q <= first_fall;
                  stat_q    <= ~last_edge;
                  state_q   <= last_edge ? ST_TAIL : ST_STRM;
               end else begin
                  stat_q  <= 1'b0;
                  state_q <= ST_BASIC;
               end
            end
            ST_BASIC: begin
               if (rdy_rtn) begin
                  cmd_q   <= 1'b0;
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            ST_STRM: begin
               if (counted) started_q <= 1'b1;
               if (!sdr_in && started_q) slv_end_q <= 1'b1;
               if (end_ev) begin
                  stat_q  <= 1'b0;
                  cmd_q   <= 1'b0;
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else if (last_edge) begin
                  strb_q  <= 1'b1;
                  stat_q  <= 1'b0;
                  state_q <= ST_TAIL;
               end else if (fall_ev) begin
                  strb_q <= 1'b1;
               end else if (rise_ev) begin
                  strb_q <= 1'b0;
               end
            end
            ST_TAIL: begin
               strb_q  <= 1'b0;
               cmd_q   <= 1'b0;
               done_q  <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy       = (state_q != ST_IDLE);
   assign bus_addr   = addr_q;
   assign stat_wr_o  = stat_q & wr_q;
   assign stat_rd_o  = stat_q & ~wr_q;
   assign adl_o      = adl_q;
   assign cmd_o      = cmd_q;
   assign strb_o     = strb_q;
   assign beat_take  = take_q;
   assign beat_retry = retry_q;
   assign done_o     = done_q;
endmodule

// File: rtl/sbm_checker.sv
module sbm_checker
   import sbm_pkg::*;
#(
   parameter int unsigned PRE_LIM = 780
) (
   input logic       clk,
   input logic       rst_n,
   input logic       stall,
   input logic       sdr_in,
   input logic       preempt,
   input sbm_state_e state,
   input logic       pre_exp,
   input logic       adl_o,
   input logic       cmd_o,
   input logic       strb_o,
   input logic       stat_wr_o,
   input logic       stat_rd_o,
   input logic       beat_take,
   input logic       beat_retry,
   input logic       done_o
);
   localparam int unsigned CW = $clog2(PRE_LIM + 6);

   logic          took_q, armed_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         took_q  <= 1'b0;
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else if (!cmd_o) begin
         took_q  <= 1'b0;
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else begin
         if (beat_take) took_q <= 1'b1;
         if (preempt && took_q) armed_q <= 1'b1;
         if (armed_q && cnt_q != CW'(PRE_LIM + 5)) cnt_q <= cnt_q + 1'b1;
      end
   end

   a_r1_latch_before_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      adl_o |-> ((stat_wr_o || stat_rd_o) && !cmd_o));

   a_r1_cmd_follows_latch: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_o) |-> $past(adl_o));

   a_r2_fallback_drops_status: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(adl_o) && !$past(sdr_in)) |-> (!stat_wr_o && !stat_rd_o && cmd_o && !strb_o));

   a_r4_one_decision_per_edge: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strb_o) |-> (beat_take ^ beat_retry));

   a_r4_strobe_inside_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      strb_o |-> cmd_o);

   a_r7_preempt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(PRE_LIM + 4));

   a_r8_stall_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STRM && stall && !pre_exp) |=> ($stable(strb_o) && !beat_take && !beat_retry));

   a_r10_done_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!cmd_o && $past(cmd_o)));
endmodule

bind stream_burst_master sbm_checker #(.PRE_LIM(PRE_LIM)) u_sbm_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .stall     (stall),
   .sdr_in    (sdr_in),
   .preempt   (preempt),
   .state     (state_q),
   .pre_exp   (pre_exp),
   .adl_o     (adl_o),
   .cmd_o     (cmd_o),
   .strb_o    (strb_o),
   .stat_wr_o (stat_wr_o),
   .stat_rd_o (stat_rd_o),
   .beat_take (beat_take),
   .beat_retry(beat_retry),
   .done_o    (done_o)
);

// File: tb/stream_burst_master_bench.sv
module stream_burst_master_bench;
   localparam int unsigned AW = 16;
   localparam int unsigned LW = 12;
   localparam int unsigned PL = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0, start_wr = 1'b0, start_wide = 1'b0, start_io = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic [LW-1:0] start_len = '0;
   logic          stall = 1'b0, rdy_rtn = 1'b0, sdr_in = 1'b0, preempt = 1'b0;
   logic          busy, stat_wr_o, stat_rd_o, adl_o, cmd_o, strb_o;
   logic          beat_take, beat_retry, done_o;
   logic [AW-1:0] bus_addr, resume_addr;
   logic [LW-1:0] bytes_done;

   int n_chk = 0;
   int n_fail = 0;
   int exp_q[$];

   always #5 clk = ~clk;

   stream_burst_master #(.AW(AW), .LW(LW), .WIDE_EN(1'b1), .PRE_LIM(PL)) u_stream_burst_master (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .start_len(start_len),
      .start_wr(start_wr), .start_wide(start_wide), .start_io(start_io), .stall(stall),
      .rdy_rtn(rdy_rtn), .sdr_in(sdr_in), .preempt(preempt), .busy(busy), .bus_addr(bus_addr),
      .stat_wr_o(stat_wr_o), .stat_rd_o(stat_rd_o), .adl_o(adl_o), .cmd_o(cmd_o),
      .strb_o(strb_o), .beat_take(beat_take), .beat_retry(beat_retry), .done_o(done_o),
      .bytes_done(bytes_done), .resume_addr(resume_addr)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic launch(input logic [AW-1:0] a, input logic [LW-1:0] l,
                         input logic w, input logic wd, input logic io);
      start = 1'b1; start_addr = a; start_len = l;
      start_wr = w; start_wide = wd; start_io = io;
      tick();
      start = 1'b0;
   endtask

   // scoreboard monitor: each counted beat must match the next expected total
   always @(negedge clk) begin
      if (rst_n && beat_take) begin
         n_chk++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R4 beat: actual unexpected beat total %0d expected none", bytes_done);
         end else begin
            int e;
            e = exp_q.pop_front();
            if (int'(bytes_done) != e) begin
               n_fail++;
               $display("FAIL R5 beat total: actual %0d expected %0d", bytes_done, e);
            end
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 busy", busy, 0);
      chk("R10 cmd", cmd_o, 0);
      chk("R10 strb", strb_o, 0);
      chk("R10 stat", stat_wr_o | stat_rd_o, 0);
      chk("R10 bytes", bytes_done, 0);
      rst_n = 1'b1;
      tick();

      // basic fallback (R1, R2)
      sdr_in = 1'b0; rdy_rtn = 1'b0;
      exp_q.push_back(4);
      launch(16'h0100, 12'd8, 1'b1, 1'b1, 1'b0);
      chk("R1 status", stat_wr_o, 1);
      chk("R1 addr", bus_addr, 16'h0100);
      chk("R1 no latch yet", adl_o, 0);
      tick();
      chk("R1 latch", adl_o, 1);
      chk("R1 no cmd", cmd_o, 0);
      tick();
      chk("R1 cmd", cmd_o, 1);
      chk("R1 latch off", adl_o, 0);
      chk("R2 status off", stat_wr_o, 0);
      chk("R2 no strobe", strb_o, 0);
      tick();
      chk("R2 cmd held", cmd_o, 1);
      rdy_rtn = 1'b1;
      tick();
      chk("R2 cmd off", cmd_o, 0);
      chk("R10 done", done_o, 1);
      chk("R2 bytes", bytes_done, 4);
      chk("R9 mem resume", resume_addr, 16'h0104);
      rdy_rtn = 1'b0;
      tick();

      // stream with one repeat (R3, R4, R5)
      sdr_in = 1'b1; rdy_rtn = 1'b1;
      exp_q.push_back(4); exp_q.push_back(8); exp_q.push_back(12);
      launch(16'h0200, 12'd12, 1'b1, 1'b1, 1'b0);
      tick(); tick();
      chk("R3 strobe with cmd", strb_o, 1);
      chk("R3 cmd", cmd_o, 1);
      rdy_rtn = 1'b0;
      tick();
      chk("R4 strobe high phase", strb_o, 0);
      tick();
      chk("R4 edge while not ready", strb_o, 1);
      chk("R4 retry", beat_retry, 1);
      chk("R4 bytes unchanged", bytes_done, 4);
      rdy_rtn = 1'b1;
      tick(); tick();
      chk("R4 counted", bytes_done, 8);
      tick(); tick();
      chk("R5 status drops on last edge", stat_wr_o, 0);
      chk("R5 cmd still on", cmd_o, 1);
      tick();
      chk("R5 cmd off", cmd_o, 0);
      chk("R5 done", done_o, 1);
      chk("R5 total", bytes_done, 12);
      tick();

      // deferred start, narrow read, partial last beat (R3, R5)
      rdy_rtn = 1'b0;
      exp_q.push_back(2); exp_q.push_back(3);
      launch(16'h0300, 12'd3, 1'b0, 1'b0, 1'b0);
      tick(); tick();
      chk("R3 deferred strobe", strb_o, 0);
      chk("R1 read status", stat_rd_o, 1);
      tick();
      chk("R3 still deferred", strb_o, 0);
      rdy_rtn = 1'b1;
      tick();
      chk("R3 strobe after ready", strb_o, 1);
      tick(); tick();
      chk("R5 read status off", stat_rd_o, 0);
      tick();
      chk("R5 partial total", bytes_done, 3);
      tick();

      // master stall in both phases (R8)
      exp_q.push_back(4); exp_q.push_back(8);
      launch(16'h0400, 12'd8, 1'b1, 1'b1, 1'b0);
      tick(); tick();
      stall = 1'b1;
      for (int i = 0; i < 3; i++) begin
         tick();
         chk("R8 low phase held", strb_o, 1);
      end
      stall = 1'b0;
      tick();
      chk("R8 released", strb_o, 0);
      stall = 1'b1;
      tick(); tick();
      chk("R8 high phase held", strb_o, 0);
      chk("R8 no beat", bytes_done, 4);
      stall = 1'b0;
      tick();
      chk("R8 edge after release", strb_o, 1);
      tick();
      chk("R8 total", bytes_done, 8);
      tick();

      // slave ends the burst (R6, R9)
      exp_q.push_back(4); exp_q.push_back(8);
      launch(16'h0500, 12'd40, 1'b1, 1'b1, 1'b0);
      tick(); tick(); tick(); tick();
      sdr_in = 1'b0;
      tick();
      chk("R6 cmd until next edge slot", cmd_o, 1);
      chk("R6 strobe high", strb_o, 0);
      tick();
      chk("R6 cmd off", cmd_o, 0);
      chk("R6 status off", stat_wr_o, 0);
      chk("R6 done", done_o, 1);
      chk("R6 no extra beat", bytes_done, 8);
      chk("R9 mem resume", resume_addr, 16'h0508);
      sdr_in = 1'b1;
      tick();

      // preempt with stall held (R7, R9 io)
      exp_q.push_back(4); exp_q.push_back(8);
      launch(16'h0600, 12'd400, 1'b0, 1'b1, 1'b1);
      tick(); tick();
      preempt = 1'b1; stall = 1'b1;
      begin
         int n;
         n = 0;
         while (cmd_o && n < 60) begin
            tick();
            n++;
         end
         chk("R7 released within bound", (n <= PL + 4) ? 1 : 0, 1);
         chk("R7 held at least limit", (n >= PL) ? 1 : 0, 1);
      end
      chk("R7 total", bytes_done, 8);
      chk("R9 io resume", resume_addr, 16'h0600);
      preempt = 1'b0; stall = 1'b0;
      tick();

      chk("R4 scoreboard drained", exp_q.size(), 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule